// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Unit

This block gathers the event flags raised by a memory-card host controller's command and data engines into one sticky status word, and turns that word into two level interrupt lines. Each line has its own 32-bit enable mask. A line is high while any status bit that its mask enables is set. Software clears events by writing ones to a clear register, and only the eleven event bits at the bottom of the word can be cleared that way. The upper bits report FIFO state and are cleared only by reset.

The block also decodes the host register window for the controller's small configuration registers: a power byte, a clock byte, the command argument and the command word. It passes a 16-word aliased data window through to the data FIFO. A host read that takes a word out of the FIFO arms a hold, and the hold stops the data engine from moving more data. The hold is released when the host reads the status word or the FIFO word count. That read still returns the value the register had before the release took effect. The hold keeps new data from arriving while software is still draining the FIFO.

Host accesses are single-cycle. The bus address is a word index, so a byte offset maps to the index offset/4. Read data is combinational from the state held before the access, and every side effect of the access takes effect at the following clock edge.

Top module: `card_evt_irq`

## Requirements
- R1: After reset the status word, both masks, the power, clock, argument and command registers and the hold flag are all zero, so both interrupt lines are low and `move_en` is high.
- R2: A 1 on bit n of `evt_set` sets status bit n at the next clock edge. The bit stays set until it is cleared by a write or by reset.
- R3: A write to the clear register (byte offset 0x38) clears each status bit in 10:0 whose written bit is 1. Status bits 21:11 are never changed by this write.
- R4: When a set request and a clear target the same status bit in the same cycle, the bit ends up set.
- R5: `irq[0]` is high exactly when status AND mask0 (byte offset 0x3C) is nonzero, and `irq[1]` is high exactly when status AND mask1 (byte offset 0x40) is nonzero. Both lines follow the state after each access.
- R6: A read in the data window while `fifo_empty` is low pulses `fifo_pop` for that cycle and returns `fifo_rdata`. From the next edge on it holds data movement off (`move_en` low).
- R7: A read of status (byte offset 0x34) or of the FIFO count (byte offset 0x48) releases the hold, so `move_en` is high from the next edge. A status read returns the status word as it stood before that cycle's set requests.
- R8: A FIFO-count read returns the number of 32-bit words that `byte_cnt` bytes fill, rounded up: (byte_cnt+3)/4.
- R9: All 16 word addresses from byte offset 0x80 to 0xBC reach the same FIFO port. A window read while `fifo_empty` is high returns 0, does not pop and does not arm the hold.
- R10: A window write pulses `fifo_push` with `fifo_wdata` equal to the written word when `byte_cnt` is nonzero. When `byte_cnt` is zero the write is dropped and no push happens.
- R11: The power (byte offset 0x00) and clock (byte offset 0x04) registers keep the low 8 bits of the written word. The argument (byte offset 0x08) and command (byte offset 0x0C) registers keep all 32 bits. All four read back what they hold.
- R12: Reads of unmapped addresses return 0. Writes to unmapped addresses, and writes to the status or FIFO-count registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| evt_set | input | 22 | Per-bit status set requests from the engines |
| byte_cnt | input | 16 | Bytes left in the current data transfer |
| fifo_empty | input | 1 | Data FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Take the head word out of the FIFO |
| fifo_push | output | 1 | Write `fifo_wdata` into the FIFO |
| fifo_wdata | output | 32 | Word to be pushed |
| move_en | output | 1 | Data movement allowed (hold released) |
| pwr_cfg | output | 8 | Power register |
| clk_cfg | output | 8 | Clock register |
| cmd_arg | output | 32 | Command argument register |
| cmd_word | output | 32 | Command register |
| irq | output | 2 | Level interrupt lines |

## Verification
Status bits are set in sparse patterns that cover both halves of the word, so a clear that reaches past bit 10 shows up as a missing upper bit. Masks are written with bits that overlap the status word and bits that do not, so a line tied to the wrong mask or to the unmasked word raises a mismatch. Same-cycle set and clear on one bit tells set priority from clear priority. The hold is armed and released through both release registers. FIFO reads are made at several aliased window addresses with the FIFO full and empty. Window writes are made with a zero and a nonzero byte count, and each one shows whether a pop, a push or the hold fired when it should not.

// File: rtl/card_evt_pkg.sv
package card_evt_pkg;
  localparam int STAT_W   = 22;
  localparam int CLR_W    = 11;
  localparam int DATA_W   = 32;
  localparam int WADDR_W  = 10;
  localparam int CNT_W    = 16;
  localparam int NUM_IRQ  = 2;
  localparam int WIN_WORDS = 16;

  // word indices (byte offset / 4)
  localparam logic [WADDR_W-1:0] IX_PWR  = WADDR_W'(8'h00 >> 2);
  localparam logic [WADDR_W-1:0] IX_CLKD = WADDR_W'(8'h04 >> 2);
  localparam logic [WADDR_W-1:0] IX_ARG  = WADDR_W'(8'h08 >> 2);
  localparam logic [WADDR_W-1:0] IX_CMD  = WADDR_W'(8'h0C >> 2);
  localparam logic [WADDR_W-1:0] IX_STAT = WADDR_W'(8'h34 >> 2);
  localparam logic [WADDR_W-1:0] IX_CLR  = WADDR_W'(8'h38 >> 2);
  localparam logic [WADDR_W-1:0] IX_MSK0 = WADDR_W'(8'h3C >> 2);
  localparam logic [WADDR_W-1:0] IX_MSK1 = WADDR_W'(8'h40 >> 2);
  localparam logic [WADDR_W-1:0] IX_FCNT = WADDR_W'(8'h48 >> 2);
  localparam logic [WADDR_W-1:0] IX_WIN  = WADDR_W'(8'h80 >> 2);

  typedef struct packed {
    logic pwr;
    logic clkd;
    logic arg;
    logic cmd;
    logic stat;
    logic clr;
    logic msk0;
    logic msk1;
    logic fcnt;
    logic win;
  } hit_t;

  // bits of a clear write that may reach the status word
  function automatic logic [STAT_W-1:0] clr_reach(input logic [DATA_W-1:0] w);
    logic [STAT_W-1:0] r;
    r = '0;
    r[CLR_W-1:0] = w[CLR_W-1:0];
    return r;
  endfunction

  // next sticky status: set requests take priority over clears
  function automatic logic [STAT_W-1:0] stat_next(input logic [STAT_W-1:0] cur,
                                                  input logic [STAT_W-1:0] set,
                                                  input logic [STAT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // words needed to carry a byte count, rounded up
  function automatic logic [DATA_W-1:0] words_of(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = {1'b0, n} + (CNT_W+1)'(3);
    return DATA_W'(s >> 2);
  endfunction

  function automatic logic any_enabled(input logic [STAT_W-1:0] st,
                                       input logic [DATA_W-1:0] m);
    return |(st & m[STAT_W-1:0]);
  endfunction
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import card_evt_pkg::*;
(
  input  logic [WADDR_W-1:0] addr,
  output hit_t               hit
);
  localparam int WIN_LO = int'(IX_WIN);
  localparam int WIN_HI = WIN_LO + WIN_WORDS;

  always_comb begin
    hit      = '0;
    hit.pwr  = (addr == IX_PWR);
    hit.clkd = (addr == IX_CLKD);
    hit.arg  = (addr == IX_ARG);
    hit.cmd  = (addr == IX_CMD);
    hit.stat = (addr == IX_STAT);
    hit.clr  = (addr == IX_CLR);
    hit.msk0 = (addr == IX_MSK0);
    hit.msk1 = (addr == IX_MSK1);
    hit.fcnt = (addr == IX_FCNT);
    hit.win  = (int'(addr) >= WIN_LO) && (int'(addr) < WIN_HI);
  end
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import card_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_q;

  assign clr_vec  = clr_we_i ? clr_reach(clr_data_i) : '0;
  assign status_o = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= stat_next(status_q, set_i, clr_vec);
  end

  // R2 / R4: every requested bit is set after the edge, whatever the clear did
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R2: a bit only rises when it was requested
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));

  // R3: the upper bits never fall outside reset
  p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q[STAT_W-1:CLR_W] & $past(status_q[STAT_W-1:CLR_W]))
              == $past(status_q[STAT_W-1:CLR_W])));
endmodule

// File: rtl/evt_hold_ctrl.sv
module evt_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic release_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (arm_i)     hold_q <= 1'b1;
    else if (release_i) hold_q <= 1'b0;
  end

  assign hold_o = hold_q;

  // R6: a popping read arms the hold
  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> hold_q);

  // R6: the hold only rises after a popping read
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(arm_i));

  // R7: a release read drops the hold
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !arm_i) |=> !hold_q);
endmodule

// File: rtl/card_evt_irq.sv
module card_evt_irq
  import card_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [STAT_W-1:0]  evt_set,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic               fifo_empty,
  input  logic [DATA_W-1:0]  fifo_rdata,
  output logic               fifo_pop,
  output logic               fifo_push,
  output logic [DATA_W-1:0]  fifo_wdata,
  output logic               move_en,
  output logic [7:0]         pwr_cfg,
  output logic [7:0]         clk_cfg,
  output logic [DATA_W-1:0]  cmd_arg,
  output logic [DATA_W-1:0]  cmd_word,
  output logic [NUM_IRQ-1:0] irq
);
  hit_t              hit;
  logic              wr_s, rd_s;
  logic              clr_wr_s;
  logic              hold_arm_s, hold_rel_s;
  logic              hold;
  logic [STAT_W-1:0] status;
  logic [NUM_IRQ-1:0] mask_wr_s;
  logic [DATA_W-1:0] mask_q [NUM_IRQ];

  evt_addr_decode u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign wr_s     = bus_sel &  bus_wr;
  assign rd_s     = bus_sel & ~bus_wr;
  assign clr_wr_s = wr_s & hit.clr;

  evt_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_we_i   (clr_wr_s),
    .clr_data_i (bus_wdata),
    .status_o   (status)
  );

  // FIFO window
  assign fifo_pop   = rd_s & hit.win & ~fifo_empty;
  assign fifo_push  = wr_s & hit.win & (byte_cnt != '0);
  assign fifo_wdata = bus_wdata;

  assign hold_arm_s = fifo_pop;
  assign hold_rel_s = rd_s & (hit.stat | hit.fcnt);

  evt_hold_ctrl u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (hold_arm_s),
    .release_i (hold_rel_s),
    .hold_o    (hold)
  );

  assign move_en = ~hold;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_cfg  <= '0;
      clk_cfg  <= '0;
      cmd_arg  <= '0;
      cmd_word <= '0;
    end else if (wr_s) begin
      if (hit.pwr)  pwr_cfg  <= bus_wdata[7:0];
      if (hit.clkd) clk_cfg  <= bus_wdata[7:0];
      if (hit.arg)  cmd_arg  <= bus_wdata;
      if (hit.cmd)  cmd_word <= bus_wdata;
    end
  end

  // mask registers and interrupt lines
  assign mask_wr_s[0] = wr_s & hit.msk0;
  assign mask_wr_s[1] = wr_s & hit.msk1;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)            mask_q[i] <= '0;
      else if (mask_wr_s[i]) mask_q[i] <= bus_wdata;
    end

    assign irq[i] = any_enabled(status, mask_q[i]);

    // R5: a line only falls after a clear or a write to its own mask
    p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(clr_wr_s | mask_wr_s[i]));

    // R5: a line only rises after a set request or a write to its own mask
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past((|evt_set) | mask_wr_s[i]));
  end

  // read mux, from pre-access state
  always_comb begin
    bus_rdata = '0;
    if (rd_s) begin
      unique case (1'b1)
        hit.pwr:  bus_rdata = DATA_W'(pwr_cfg);
        hit.clkd: bus_rdata = DATA_W'(clk_cfg);
        hit.arg:  bus_rdata = cmd_arg;
        hit.cmd:  bus_rdata = cmd_word;
        hit.stat: bus_rdata = DATA_W'(status);
        hit.msk0: bus_rdata = mask_q[0];
        hit.msk1: bus_rdata = mask_q[1];
        hit.fcnt: bus_rdata = words_of(byte_cnt);
        hit.win:  bus_rdata = fifo_empty ? '0 : fifo_rdata;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R10: nothing is pushed while no bytes remain
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt == '0) |-> !fifo_push);

  // R12: status never changes in response to a plain register write other than clear
  p_stat_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && !hit.clr && evt_set == '0) |=> $stable(status));
endmodule

// File: tb/card_evt_irq_tb.sv
module card_evt_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [21:0] evt_set = '0;
  logic [15:0] byte_cnt = '0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_rdata = '0;
  logic        fifo_pop, fifo_push, move_en;
  logic [31:0] fifo_wdata, cmd_arg, cmd_word;
  logic [7:0]  pwr_cfg, clk_cfg;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        last_pop, last_push;
  logic [31:0] last_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_evt_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .byte_cnt(byte_cnt), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .move_en(move_en), .pwr_cfg(pwr_cfg),
    .clk_cfg(clk_cfg), .cmd_arg(cmd_arg), .cmd_word(cmd_word), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [31:0] byte_off, input logic [31:0] exp,
                    input string tag, input logic [21:0] setv = '0);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = byte_off[11:2]; evt_set = setv;
    @(negedge clk); #1;
    last_pop = fifo_pop; last_push = fifo_push;
    @(posedge clk); #1;
    bus_sel = 1'b0; evt_set = '0;
  endtask

  task automatic wr(input logic [31:0] byte_off, input logic [31:0] data,
                    input logic [21:0] setv = '0);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = byte_off[11:2];
    bus_wdata = data; evt_set = setv;
    @(negedge clk); #1;
    last_pop = fifo_pop; last_push = fifo_push; last_wdata = fifo_wdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
  endtask

  task automatic pulse_set(input logic [21:0] v);
    @(posedge clk); #1; evt_set = v;
    @(posedge clk); #1; evt_set = '0;
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {30'd0, irq}, 32'd0);
    chk("R1 move_en", {31'd0, move_en}, 32'd1);
    rd(32'h34, 32'd0, "R1 status");
    rd(32'h3C, 32'd0, "R1 mask0");
    rd(32'h40, 32'd0, "R1 mask1");
    rd(32'h00, 32'd0, "R1 power");
    rd(32'h0C, 32'd0, "R1 command");

    // R11 configuration registers
    wr(32'h00, 32'h1234_56AB);
    wr(32'h04, 32'hFFFF_FF3C);
    wr(32'h08, 32'hDEAD_BEEF);
    wr(32'h0C, 32'h8765_4321);
    rd(32'h00, 32'h0000_00AB, "R11 power 8 bits");
    rd(32'h04, 32'h0000_003C, "R11 clock 8 bits");
    rd(32'h08, 32'hDEAD_BEEF, "R11 argument");
    rd(32'h0C, 32'h8765_4321, "R11 command");
    chk("R11 pwr_cfg port", {24'd0, pwr_cfg}, 32'hAB);

    // R2 sticky set
    pulse_set(22'h000041);
    rd(32'h34, 32'h41, "R2 set");
    rd(32'h34, 32'h41, "R2 sticky");
    pulse_set(22'h200800);
    rd(32'h34, 32'h200841, "R2 upper set");

    // R3 clear limited to 10:0
    wr(32'h38, 32'hFFFF_FFFF);
    rd(32'h34, 32'h200800, "R3 clear reach");
    pulse_set(22'h000006);
    wr(32'h38, 32'h0000_0002);
    rd(32'h34, 32'h200804, "R3 selective clear");

    // R5 masks
    wr(32'h3C, 32'h0000_0800);
    chk("R5 irq0 on", {31'd0, irq[0]}, 32'd1);
    chk("R5 irq1 off", {31'd0, irq[1]}, 32'd0);
    wr(32'h40, 32'h0010_0000);
    chk("R5 irq1 unmatched", {31'd0, irq[1]}, 32'd0);
    wr(32'h40, 32'h0020_0000);
    chk("R5 irq1 on", {31'd0, irq[1]}, 32'd1);
    wr(32'h3C, 32'h0000_0001);
    chk("R5 irq0 off", {31'd0, irq[0]}, 32'd0);
    pulse_set(22'h000001);
    chk("R5 irq0 rise", {31'd0, irq[0]}, 32'd1);
    wr(32'h38, 32'h0000_0001);
    chk("R5 irq0 cleared", {31'd0, irq[0]}, 32'd0);
    rd(32'h3C, 32'h1, "R5 mask0 readback");

    // R4 set beats clear
    wr(32'h38, 32'h0000_0004, 22'h000004);
    rd(32'h34, 32'h200804, "R4 set wins");

    // R6 / R9 FIFO reads and aliasing
    fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_F00D;
    rd(32'h80, 32'hCAFE_F00D, "R6 window read");
    chk("R6 pop", {31'd0, last_pop}, 32'd1);
    chk("R6 hold armed", {31'd0, move_en}, 32'd0);
    fifo_rdata = 32'h0BAD_1DEA;
    rd(32'hBC, 32'h0BAD_1DEA, "R9 alias top");
    chk("R9 alias pop", {31'd0, last_pop}, 32'd1);
    chk("R6 still held", {31'd0, move_en}, 32'd0);
    // R7 status read releases, returns pre-set value
    rd(32'h34, 32'h200804, "R7 status pre-value", 22'h000008);
    chk("R7 released by status", {31'd0, move_en}, 32'd1);
    rd(32'h34, 32'h20080C, "R7 set after read");
    // R7 / R8 release by FIFO count
    rd(32'hA4, 32'h0BAD_1DEA, "R9 alias mid");
    chk("R6 armed again", {31'd0, move_en}, 32'd0);
    byte_cnt = 16'd5;
    rd(32'h48, 32'd2, "R8 count 5 bytes");
    chk("R7 released by count", {31'd0, move_en}, 32'd1);
    byte_cnt = 16'd8;
    rd(32'h48, 32'd2, "R8 count 8 bytes");
    byte_cnt = 16'hFFFF;
    rd(32'h48, 32'h4000, "R8 count max");
    byte_cnt = 16'd0;
    rd(32'h48, 32'd0, "R8 count zero");

    // R9 empty read
    fifo_empty = 1'b1;
    rd(32'h90, 32'd0, "R9 empty read");
    chk("R9 no pop", {31'd0, last_pop}, 32'd0);
    chk("R9 no hold", {31'd0, move_en}, 32'd1);

    // R10 window writes
    wr(32'h84, 32'h1111_2222);
    chk("R10 dropped", {31'd0, last_push}, 32'd0);
    byte_cnt = 16'd4;
    wr(32'hB0, 32'h3333_4444);
    chk("R10 push", {31'd0, last_push}, 32'd1);
    chk("R10 data", last_wdata, 32'h3333_4444);
    byte_cnt = 16'd0;

    // R12 unmapped / read-only
    wr(32'h44, 32'hFFFF_FFFF);
    wr(32'h34, 32'h0000_0000);
    wr(32'h48, 32'hFFFF_FFFF);
    rd(32'h44, 32'd0, "R12 unmapped read");
    rd(32'h100, 32'd0, "R12 far unmapped");
    rd(32'h34, 32'h20080C, "R12 status untouched");
    rd(32'h3C, 32'h1, "R12 mask0 untouched");
    rd(32'h40, 32'h0020_0000, "R12 mask1 untouched");

    repeat (2) @(posedge clk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule